// File: doc/BRIEF.md
# Windowed Register-Write Watchdog

This block watches the traffic a host sends to a device's register file and raises an alarm when that traffic stops. A free prescaler divides a base tick enable by `PRESCALE` to form the watchdog tick. A counter of those ticks is compared against a late limit, which a 2-bit code selects. A second 2-bit code selects an early limit. While that code is zero the block is a plain timeout: any register write restarts the count. Any other value makes it a window checker. Then only a write to the watchdog's own control register restarts the count, and such a write is an error if it comes too soon.

An error latches a condition that drives the active-low alarm and sets a sticky fault flag. The condition stays until the enable input goes low or a reset arrives. The flag then stays until a status read is seen while the condition is already clear. The surrounding register file supplies the enable level, the limit codes and the write and read strobes, one cycle each.

Top module: `window_watchdog`

## Requirements
- R1: While `rst_n` is low and right after it rises, `alarm_n` is 1 and `fault` is 0; a hardware reset at any time clears both.
- R2: While `wd_en` is 0, prescaler and counter are held at zero and no error is raised, whatever the write and read strobes do.
- R3: Counting advances only on cycles with `base_tick` high: every `PRESCALE` base ticks give one watchdog tick. Late code 0,1,2,3 selects `LATE_T0..LATE_T3` watchdog ticks. With `early_code` = 0 and no writes, the error is latched on the base tick that completes `LATE_Tn * PRESCALE` base ticks since enabling.
- R4: With `early_code` = 0, a pulse on `any_wr` or `own_wr` restarts prescaler and counter from zero, so the next error comes `LATE_Tn * PRESCALE` base ticks after that write.
- R5: With `early_code` = 1,2,3 (early limit `EARLY_T1..EARLY_T3` ticks), an `own_wr` sampled while the tick count is below the early limit latches an error at that edge.
- R6: With `early_code` non-zero, an `own_wr` at or past the early limit restarts the count, while `any_wr` alone has no effect on the timing.
- R7: A valid restart write sampled on the same edge as the expiring tick wins: no error, and the count restarts.
- R8: An error drives `alarm_n` low and sets `fault` at the same edge; `fault` stays 1 while the condition persists.
- R9: While `wd_en` stays 1 the latched condition persists and further writes have no effect; `wd_en` at 0 clears it at the next edge.
- R10: `status_rd` clears `fault` only when the condition is already clear at that edge; a read during the condition leaves `fault` at 1.
- R11: Enabling starts the timing from zero, so a fresh run after re-enabling lasts the full late interval.
- R12: A restart write and a status read on the same edge are both acted on.
- R13: A `sw_reset` pulse clears condition, flag, prescaler and counter; if `wd_en` stays 1, timing restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_reset | input | 1 | Synchronous software reset pulse |
| base_tick | input | 1 | Base time enable, one cycle per base period |
| any_wr | input | 1 | Pulse for a write to any register |
| own_wr | input | 1 | Pulse for a write to the watchdog control register |
| wd_en | input | 1 | Watchdog enable level |
| late_code | input | 2 | Late-limit select |
| early_code | input | 2 | Early-limit select, 0 means plain timeout |
| status_rd | input | 1 | Pulse for a read of the alarm status register |
| alarm_n | output | 1 | Alarm, low while the watchdog condition is latched |
| fault | output | 1 | Sticky watchdog fault flag |

## Verification
The properties assume that strobes are single-cycle, synchronous pulses and that `rst_n` is the only asynchronous input. They also assume `sw_reset` clears everything on the edge where it is sampled, even if that edge also brings a read or a write. The bench drives every input at the falling edge and lowers each strobe just after the next rising edge, so each write, read or reset is sampled by exactly one edge. The limit codes change only while `wd_en` is low, so the properties about the window never see a limit shift under a running count.

// File: rtl/window_watchdog.sv
module window_watchdog #(
  parameter int PRESCALE = 1024,
  parameter int LATE_T0  = 64,
  parameter int LATE_T1  = 128,
  parameter int LATE_T2  = 256,
  parameter int LATE_T3  = 512,
  parameter int EARLY_T1 = 8,
  parameter int EARLY_T2 = 16,
  parameter int EARLY_T3 = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_reset,
  input  logic       base_tick,
  input  logic       any_wr,
  input  logic       own_wr,
  input  logic       wd_en,
  input  logic [1:0] late_code,
  input  logic [1:0] early_code,
  input  logic       status_rd,
  output logic       alarm_n,
  output logic       fault
);
  localparam int PW    = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int LM01  = (LATE_T0 > LATE_T1) ? LATE_T0 : LATE_T1;
  localparam int LM23  = (LATE_T2 > LATE_T3) ? LATE_T2 : LATE_T3;
  localparam int LMAX  = (LM01 > LM23) ? LM01 : LM23;
  localparam int CW    = $clog2(LMAX + 1);

  logic [PW-1:0] pre_q;
  logic [CW-1:0] cnt_q;
  logic          err_q, flag_q;
  logic [CW:0]   late_lim, early_lim;

  always_comb begin
    case (late_code)
      2'd0:    late_lim = (CW+1)'(LATE_T0);
      2'd1:    late_lim = (CW+1)'(LATE_T1);
      2'd2:    late_lim = (CW+1)'(LATE_T2);
      default: late_lim = (CW+1)'(LATE_T3);
    endcase
    case (early_code)
      2'd1:    early_lim = (CW+1)'(EARLY_T1);
      2'd2:    early_lim = (CW+1)'(EARLY_T2);
      2'd3:    early_lim = (CW+1)'(EARLY_T3);
      default: early_lim = '0;
    endcase
  end

  wire window  = early_code != 2'd0;
  wire active  = wd_en && !err_q;
  wire kick    = active && (window ? own_wr : (any_wr || own_wr));
  wire wd_tick = active && base_tick && (pre_q == PW'(PRESCALE - 1));
  wire early_e = window && kick && ({1'b0, cnt_q} < early_lim);
  wire late_e  = !kick && wd_tick && (({1'b0, cnt_q} + (CW+1)'(1)) >= late_lim);
  wire err_set = early_e || late_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
      flag_q <= 1'b0;
    end else if (sw_reset) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (!wd_en) begin
        pre_q <= '0;
        cnt_q <= '0;
        err_q <= 1'b0;
      end else if (!err_q) begin
        if (err_set) err_q <= 1'b1;
        if (kick) begin
          pre_q <= '0;
          cnt_q <= '0;
        end else if (wd_tick) begin
          pre_q <= '0;
          cnt_q <= cnt_q + CW'(1);
        end else if (base_tick) begin
          pre_q <= pre_q + PW'(1);
        end
      end
      if (err_set) flag_q <= 1'b1;
      else if (status_rd && !err_q) flag_q <= 1'b0;
    end
  end

  assign alarm_n = !err_q;
  assign fault   = flag_q;
endmodule

module window_watchdog_chk (
  input logic clk,
  input logic rst_n,
  input logic sw_reset,
  input logic wd_en,
  input logic status_rd,
  input logic alarm_n,
  input logic fault
);
  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en |=> alarm_n);
  p_alarm_implies_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_n |-> fault);
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault && !alarm_n && !sw_reset |=> fault);
  p_cond_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_n && wd_en && !sw_reset |=> !alarm_n);
  p_flag_needs_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault && !status_rd && !sw_reset |=> fault);
  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault && alarm_n && status_rd |=> !fault || !alarm_n);
  p_swreset_clears_r13: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> alarm_n && !fault);
endmodule

bind window_watchdog window_watchdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .wd_en(wd_en),
  .status_rd(status_rd), .alarm_n(alarm_n), .fault(fault)
);

// File: tb/tb_window_watchdog.sv
module tb_window_watchdog;
  localparam int P = 2;
  function automatic int lt(int c); return 4 + 2 * c; endfunction
  function automatic int et(int c); return c; endfunction

  logic clk = 0, rst_n = 0, sw_reset = 0, base_tick = 1;
  logic any_wr = 0, own_wr = 0, wd_en = 0, status_rd = 0;
  logic [1:0] late_code = 0, early_code = 0;
  wire alarm_n, fault;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  window_watchdog #(.PRESCALE(P), .LATE_T0(4), .LATE_T1(6), .LATE_T2(8), .LATE_T3(10),
                    .EARLY_T1(1), .EARLY_T2(2), .EARLY_T3(3)) dut (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .base_tick(base_tick),
    .any_wr(any_wr), .own_wr(own_wr), .wd_en(wd_en), .late_code(late_code),
    .early_code(early_code), .status_rd(status_rd), .alarm_n(alarm_n), .fault(fault));

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(bit a, bit o, bit r);
    @(negedge clk);
    any_wr = a; own_wr = o; status_rd = r;
    @(posedge clk); #1;
    any_wr = 0; own_wr = 0; status_rd = 0;
  endtask

  task automatic restart(int lc, int ec);
    @(negedge clk);
    wd_en = 0; late_code = 2'(lc); early_code = 2'(ec);
    @(posedge clk); #1;
    wd_en = 1;
  endtask

  task automatic run_to_alarm(int limit, output int n);
    n = 0;
    while (alarm_n && n < limit) begin step(0, 0, 0); n++; end
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int n, got, exp;
    bit low;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 alarm_n in reset", alarm_n, 1);
    chk("R1 fault in reset", fault, 0);
    rst_n = 1;
    step(0, 0, 0);
    chk("R1 alarm_n after reset", alarm_n, 1);
    chk("R1 fault after reset", fault, 0);

    // R2: disabled, strobes toggling
    low = 0;
    for (int k = 0; k < 120; k++) begin
      step(k % 3 == 0, k % 5 == 0, k % 7 == 0);
      if (!alarm_n || fault) low = 1;
    end
    chk("R2 no error while disabled", low, 0);

    // R3: plain timeout per late code
    for (int lc = 0; lc < 4; lc++) begin
      restart(lc, 0);
      run_to_alarm(200, n);
      chk($sformatf("R3 timeout edges code %0d", lc), n, lt(lc) * P);
      chk("R8 fault set with alarm", fault, 1);
    end

    // R3: base tick gating
    restart(0, 0);
    base_tick = 0;
    repeat (40) step(0, 0, 0);
    chk("R3 frozen without base tick", alarm_n, 1);
    base_tick = 1;
    run_to_alarm(200, n);
    chk("R3 resumes with base tick", n, lt(0) * P);
    restart(1, 0);
    base_tick = 0;
    n = 0;
    while (alarm_n && n < 400) begin step(0, 0, 0); n++; base_tick = ~base_tick; end
    base_tick = 1;
    chk("R3 half-rate base tick", n, 2 * lt(1) * P);

    // R4 R5 R6 R7: kick position sweep over all code pairs
    for (int lc = 0; lc < 4; lc++)
      for (int ec = 0; ec < 4; ec++)
        for (int j = 1; j <= lt(lc) * P; j++) begin
          restart(lc, ec);
          for (int k = 1; k < j; k++) step(0, 0, 0);
          if (ec == 0) step(1, 0, 0); else step(1, 1, 0);
          if (!alarm_n) got = j;
          else begin run_to_alarm(200, n); got = j + n; end
          exp = (ec != 0 && j <= et(ec) * P) ? j : j + lt(lc) * P;
          if (ec == 0)
            chk($sformatf("R4 plain kick lc%0d j%0d", lc, j), got, exp);
          else if (j <= et(ec) * P)
            chk($sformatf("R5 early kick lc%0d ec%0d j%0d", lc, ec, j), got, exp);
          else if (j == lt(lc) * P)
            chk($sformatf("R7 kick at expiry lc%0d ec%0d", lc, ec), got, exp);
          else
            chk($sformatf("R6 window kick lc%0d ec%0d j%0d", lc, ec, j), got, exp);
        end

    // R6: other writes ignored in window mode
    for (int j = 1; j < lt(1) * P; j++) begin
      restart(1, 1);
      for (int k = 1; k < j; k++) step(0, 0, 0);
      step(1, 0, 0);
      run_to_alarm(200, n);
      chk($sformatf("R6 any_wr ignored j%0d", j), j + n, lt(1) * P);
    end

    // R8 R9 R10 R11: sticky handling
    restart(0, 0);
    run_to_alarm(200, n);
    step(0, 0, 1);
    chk("R10 read during condition keeps fault", fault, 1);
    for (int k = 0; k < 5; k++) step(1, 1, 0);
    chk("R9 writes leave condition", alarm_n, 0);
    chk("R8 fault sticky", fault, 1);
    @(negedge clk); wd_en = 0;
    @(posedge clk); #1;
    chk("R9 disable clears condition", alarm_n, 1);
    chk("R10 fault kept until read", fault, 1);
    step(0, 0, 1);
    chk("R10 read after clear drops fault", fault, 0);
    wd_en = 1;
    run_to_alarm(200, n);
    chk("R11 full interval after re-enable", n, lt(0) * P);

    // R12: kick and read together
    restart(0, 0);
    step(0, 0, 0); step(0, 0, 0);
    chk("R12 flag still set before read", fault, 1);
    step(1, 0, 1);
    chk("R12 read handled with kick", fault, 0);
    run_to_alarm(200, n);
    chk("R12 kick handled with read", 3 + n, 3 + lt(0) * P);

    // R13: software reset
    @(negedge clk); sw_reset = 1;
    @(posedge clk); #1; sw_reset = 0;
    chk("R13 sw reset alarm_n", alarm_n, 1);
    chk("R13 sw reset fault", fault, 0);
    run_to_alarm(200, n);
    chk("R13 timing restarts after sw reset", n, lt(0) * P);

    // R1: hardware reset mid-error
    @(negedge clk); rst_n = 0;
    #1;
    chk("R1 hw reset alarm_n", alarm_n, 1);
    chk("R1 hw reset fault", fault, 0);
    @(negedge clk); rst_n = 1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule